// File: doc/BRIEF.md
# Spindle Power-Mode Controller

This block keeps track of which of four power modes the drive is in: active, idle, standby or sleep. It moves between them when the host sends a power command, when the drive is left alone for long enough, and when the drive has to reach the media. It tells the motor logic when to stop the spindle and when to start it again. It also tells the interface logic when to raise and when to drop the busy flag while a change of mode is still under way.

Time comes in on a prescaled `tick` input. The standby countdown works in steps of five seconds, and each step lasts `STEP_TICKS` ticks. A separate shorter countdown, `IDLE_TICKS` long, moves the drive from active to idle without any command. The two commands that carry a timer take an 8-bit timeout code with them. That code maps to a number of steps in a way that is not linear. A zero and the very small codes select fixed periods, and only the middle range scales with the code.

Top module: `pm_power_ctrl`

## Requirements
- R1: A timeout code of 0 selects 360 steps (30 minutes), i.e. 360*STEP_TICKS ticks.
- R2: Timeout codes 1, 2 and 3 all select 3 steps (15 seconds).
- R3: A timeout code n with 4 <= n <= 240 selects n steps (n times 5 seconds).
- R4: Timeout codes 241 to 255 select the largest period, 240 steps (20 minutes).
- R5: In active mode, after IDLE_TICKS ticks without a media access, the mode becomes idle, with no busy or motor pulse.
- R6: When a timer command has enabled the standby timer and the drive stays in active or idle, the timer expires after the decoded period. It then sets standby and pulses `spin_stop`, with no busy pulse. The count is held while the drive is in standby or sleep. After a `hw_reset` the timer is off until the next timer command.
- R7: A `media_acc` pulse in active or idle mode sets active with no busy pulse and restarts both countdowns from the edge that sampled it.
- R8: A `media_acc` pulse in standby pulses `bsy_set` and then `spin_start`. The mode stays standby, and `bsy_clr` stays low, until `motor_ready` is sampled high. At that edge the mode becomes active and `bsy_clr` pulses.
- R9: A command strobe sampled at edge k gives `bsy_set` after edge k. After edge k+1 the new mode and `bsy_clr` appear, with `spin_stop` in the same cycle if the spindle has to stop. If the target is active or idle and the spindle is stopped, `spin_start` appears after k+1 instead, and the change then waits for `motor_ready` as in R8.
- R10: In sleep mode all command strobes and `media_acc` are ignored. Only `hw_reset` leaves sleep: it spins the motor up and returns to active.
- R11: The mode encoding is 0 active, 1 idle, 2 standby, 3 sleep. After `rst_n` the mode is active, the spindle is taken as running, the standby timer is off and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled time tick, one cycle wide |
| tmr_code | input | 8 | Timeout code, sampled with a timer command |
| cmd_idle_now | input | 1 | Strobe: go to idle now |
| cmd_stby_now | input | 1 | Strobe: go to standby now |
| cmd_idle_tmr | input | 1 | Strobe: go to idle and arm the standby timer |
| cmd_stby_tmr | input | 1 | Strobe: go to standby and arm the standby timer |
| cmd_sleep | input | 1 | Strobe: go to sleep |
| media_acc | input | 1 | Pulse: a command needs the media |
| hw_reset | input | 1 | Hardware reset from the host interface |
| motor_ready | input | 1 | Spindle is up to speed |
| mode | output | 2 | Current power mode (R11 encoding) |
| bsy_set | output | 1 | Pulse: raise the busy flag |
| bsy_clr | output | 1 | Pulse: drop the busy flag |
| spin_start | output | 1 | Pulse: start the spindle |
| spin_stop | output | 1 | Pulse: stop the spindle |

## Verification
The bench measures the exact number of edges from a timer command to standby for codes at each edge of the non-linear map: 0, 1, 3, 4, 17, 240, 241 and 255. A decoder with an off-by-one range boundary, or a linear map, would show up as a wrong count. The bench holds `motor_ready` low for several cycles after a spin-up request. A design that took the spindle as ready at once would drop busy and change mode early. It leaves ticks running in standby and in sleep. A counter that was not held would then stop the spindle a second time, or leave standby or sleep without being asked. The bench also fires a media access part way through a countdown. A design that did not reload the countdown there would drop to standby a few edges early.

// File: rtl/pm_pkg.sv
// Package: mode encoding and timeout constants shared by the power-mode blocks.
// Assumes the mode encoding is visible to software and must not change.
package pm_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_IDLE    = 2'd1,
        PM_STANDBY = 2'd2,
        PM_SLEEP   = 2'd3
    } pm_mode_e;

    localparam int PM_LONG_STEPS  = 360;  // code 0: thirty minutes
    localparam int PM_SHORT_STEPS = 3;    // codes 1..3: fifteen seconds
    localparam int PM_SCALE_LO    = 4;    // first code that scales
    localparam int PM_SCALE_HI    = 240;  // last code that scales, also the cap
    localparam int PM_MAX_STEPS   = PM_LONG_STEPS;

    // True for modes in which the spindle must be turning.
    function automatic logic pm_spun(input pm_mode_e m);
        return (m == PM_ACTIVE) || (m == PM_IDLE);
    endfunction
endpackage

// File: rtl/pm_timeout_decode.sv
// pm_timeout_decode: turns the 8-bit timeout code into a tick limit.
// Purely combinational. Assumes STEP_TICKS >= 1 and that LIM_W holds
// PM_MAX_STEPS*STEP_TICKS.
module pm_timeout_decode
    import pm_pkg::*;
#(
    parameter int STEP_TICKS = 5,
    parameter int LIM_W      = 11
) (
    input  logic [7:0]       code,
    output logic [LIM_W-1:0] limit
);
    logic [8:0] steps;

    // Map the code to five-second steps: fixed periods at the low end, a cap at the top.
    always_comb begin
        if (code == 8'd0)
            steps = 9'(PM_LONG_STEPS);
        else if (code < 8'(PM_SCALE_LO))
            steps = 9'(PM_SHORT_STEPS);
        else if (code <= 8'(PM_SCALE_HI))
            steps = {1'b0, code};
        else
            steps = 9'(PM_SCALE_HI);
    end

    assign limit = LIM_W'(steps) * LIM_W'(STEP_TICKS);
endmodule

// File: rtl/pm_tick_timer.sv
// pm_tick_timer: counts ticks up to a limit and flags the tick that reaches it.
// Assumes limit >= 1. A reload wins over counting, and the count holds while
// run is low.
module pm_tick_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reload,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign expire = run && tick && (cnt == limit - W'(1));

    // Advance on each tick while running; wrap on expiry, clear on reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (reload)
            cnt <= '0;
        else if (run && tick)
            cnt <= expire ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/pm_seq.sv
// pm_seq: holds the mode and runs the busy/spindle handshake for every change.
// Assumes start is only raised when the caller allows it. It may be raised in
// any state, and then it restarts the handshake.
module pm_seq
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  pm_mode_e tgt,
    input  logic     stby_expire,
    input  logic     idle_expire,
    input  logic     to_active,
    input  logic     motor_ready,
    output pm_mode_e mode,
    output logic     in_run,
    output logic     bsy_set,
    output logic     bsy_clr,
    output logic     spin_start,
    output logic     spin_stop
);
    typedef enum logic [1:0] {SQ_RUN, SQ_BUSY, SQ_SPIN} sq_e;

    sq_e      st;
    pm_mode_e tgt_q;
    logic     spun;

    assign in_run = (st == SQ_RUN);

    // Handshake sequencer: announce busy, stop or start the spindle, then commit the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SQ_RUN;
            mode       <= PM_ACTIVE;
            tgt_q      <= PM_ACTIVE;
            spun       <= 1'b1;
            bsy_set    <= 1'b0;
            bsy_clr    <= 1'b0;
            spin_start <= 1'b0;
            spin_stop  <= 1'b0;
        end else begin
            bsy_set    <= 1'b0;
            bsy_clr    <= 1'b0;
            spin_start <= 1'b0;
            spin_stop  <= 1'b0;
            if (start) begin
                st      <= SQ_BUSY;
                tgt_q   <= tgt;
                bsy_set <= 1'b1;
            end else begin
                case (st)
                    SQ_RUN: begin
                        if (to_active) begin
                            mode <= PM_ACTIVE;
                        end else if (stby_expire) begin
                            mode      <= PM_STANDBY;
                            spin_stop <= 1'b1;
                            spun      <= 1'b0;
                        end else if (idle_expire) begin
                            mode <= PM_IDLE;
                        end
                    end
                    SQ_BUSY: begin
                        if (pm_spun(tgt_q) && !spun) begin
                            spin_start <= 1'b1;
                            st         <= SQ_SPIN;
                        end else begin
                            if (!pm_spun(tgt_q) && spun) begin
                                spin_stop <= 1'b1;
                                spun      <= 1'b0;
                            end
                            mode    <= tgt_q;
                            bsy_clr <= 1'b1;
                            st      <= SQ_RUN;
                        end
                    end
                    SQ_SPIN: begin
                        if (motor_ready) begin
                            spun    <= 1'b1;
                            mode    <= tgt_q;
                            bsy_clr <= 1'b1;
                            st      <= SQ_RUN;
                        end
                    end
                    default: st <= SQ_RUN;
                endcase
            end
        end
    end
endmodule

// File: rtl/pm_power_ctrl.sv
// pm_power_ctrl: power-mode controller top. It decodes the incoming strobes into
// mode requests, keeps the standby timer setting, and runs the two countdowns.
// Assumes the host only strobes one command at a time while busy is low.
// hw_reset is accepted in every state.
module pm_power_ctrl
    import pm_pkg::*;
#(
    parameter int STEP_TICKS = 5,
    parameter int IDLE_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] tmr_code,
    input  logic       cmd_idle_now,
    input  logic       cmd_stby_now,
    input  logic       cmd_idle_tmr,
    input  logic       cmd_stby_tmr,
    input  logic       cmd_sleep,
    input  logic       media_acc,
    input  logic       hw_reset,
    input  logic       motor_ready,
    output logic [1:0] mode,
    output logic       bsy_set,
    output logic       bsy_clr,
    output logic       spin_start,
    output logic       spin_stop
);
    localparam int LIM_W  = $clog2(PM_MAX_STEPS * STEP_TICKS + 1);
    localparam int IDLE_W = $clog2(IDLE_TICKS + 1);

    pm_mode_e          mode_e;
    pm_mode_e          tgt_mode;
    logic              run_phase;
    logic              cmd_any, cmd_ok, wake_req, direct_acc, start_req;
    logic              tmr_en;
    logic [7:0]        code_q;
    logic [LIM_W-1:0]  stby_limit;
    logic              stby_exp, idle_exp, reload;

    assign mode       = mode_e;
    assign cmd_any    = cmd_idle_now | cmd_stby_now | cmd_idle_tmr | cmd_stby_tmr | cmd_sleep;
    assign cmd_ok     = run_phase && (mode_e != PM_SLEEP) && cmd_any;
    assign wake_req   = run_phase && media_acc && (mode_e == PM_STANDBY);
    assign direct_acc = run_phase && media_acc && pm_spun(mode_e);
    assign start_req  = hw_reset | cmd_ok | wake_req;
    assign reload     = bsy_clr | direct_acc | start_req;

    // Pick the target mode of a request by fixed priority.
    always_comb begin
        if (hw_reset)
            tgt_mode = PM_ACTIVE;
        else if (cmd_sleep)
            tgt_mode = PM_SLEEP;
        else if (cmd_stby_now || cmd_stby_tmr)
            tgt_mode = PM_STANDBY;
        else if (cmd_idle_now || cmd_idle_tmr)
            tgt_mode = PM_IDLE;
        else
            tgt_mode = PM_ACTIVE;
    end

    // Standby timer setting: armed by a timer command, disarmed by hw_reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en <= 1'b0;
            code_q <= 8'd0;
        end else if (hw_reset) begin
            tmr_en <= 1'b0;
        end else if (cmd_ok && (cmd_idle_tmr || cmd_stby_tmr)) begin
            tmr_en <= 1'b1;
            code_q <= tmr_code;
        end
    end

    pm_timeout_decode #(.STEP_TICKS(STEP_TICKS), .LIM_W(LIM_W)) u_dec (
        .code  (code_q),
        .limit (stby_limit)
    );

    pm_tick_timer #(.W(LIM_W)) u_stby_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_en && run_phase && pm_spun(mode_e)),
        .reload (reload),
        .tick   (tick),
        .limit  (stby_limit),
        .expire (stby_exp)
    );

    pm_tick_timer #(.W(IDLE_W)) u_idle_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_phase && (mode_e == PM_ACTIVE)),
        .reload (reload),
        .tick   (tick),
        .limit  (IDLE_W'(IDLE_TICKS)),
        .expire (idle_exp)
    );

    pm_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_req),
        .tgt         (tgt_mode),
        .stby_expire (stby_exp),
        .idle_expire (idle_exp),
        .to_active   (direct_acc),
        .motor_ready (motor_ready),
        .mode        (mode_e),
        .in_run      (run_phase),
        .bsy_set     (bsy_set),
        .bsy_clr     (bsy_clr),
        .spin_start  (spin_start),
        .spin_stop   (spin_stop)
    );
endmodule

// File: rtl/pm_power_ctrl_chk.sv
// pm_power_ctrl_chk: protocol checker bound to pm_power_ctrl. It watches the
// busy pairing, the spin-up wait, the spindle stop and sleep stickiness.
module pm_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       in_run,
    input logic       hw_reset,
    input logic       motor_ready,
    input logic       bsy_set,
    input logic       bsy_clr,
    input logic       spin_start,
    input logic       spin_stop
);
    logic busy_open;

    // Track whether a busy period has been announced and not yet closed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_open <= 1'b0;
        else if (bsy_set)
            busy_open <= 1'b1;
        else if (bsy_clr)
            busy_open <= 1'b0;
    end

    a_r9_clr_closes_open: assert property (@(posedge clk) disable iff (!rst_n)
        bsy_clr |-> busy_open);

    a_r9_set_clr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy_set && bsy_clr));

    a_r8_spinup_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        spin_start |-> busy_open);

    a_r8_wait_motor_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !motor_ready) |=> mode[1]);

    a_r6_stop_when_dropping: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> (!mode[1] || spin_stop));

    a_r10_sleep_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && in_run && !hw_reset) |=> (mode == 2'd3));
endmodule

bind pm_power_ctrl pm_power_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .in_run      (run_phase),
    .hw_reset    (hw_reset),
    .motor_ready (motor_ready),
    .bsy_set     (bsy_set),
    .bsy_clr     (bsy_clr),
    .spin_start  (spin_start),
    .spin_stop   (spin_stop)
);

// File: tb/pm_power_ctrl_bench.sv
// Scoreboard bench: tasks queue the expected output events, and a monitor pops and compares them.
module pm_power_ctrl_bench;
    localparam int STEP = 2;
    localparam int IDLT = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [7:0] tmr_code = 8'd0;
    logic cmd_idle_now = 0, cmd_stby_now = 0, cmd_idle_tmr = 0, cmd_stby_tmr = 0, cmd_sleep = 0;
    logic media_acc = 0, hw_reset = 0, motor_ready = 0;
    logic [1:0] mode;
    logic bsy_set, bsy_clr, spin_start, spin_stop;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] prev_mode = 2'd0;

    always #10 clk = ~clk;

    pm_power_ctrl #(.STEP_TICKS(STEP), .IDLE_TICKS(IDLT)) u_pm_power_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_code(tmr_code),
        .cmd_idle_now(cmd_idle_now), .cmd_stby_now(cmd_stby_now),
        .cmd_idle_tmr(cmd_idle_tmr), .cmd_stby_tmr(cmd_stby_tmr),
        .cmd_sleep(cmd_sleep), .media_acc(media_acc), .hw_reset(hw_reset),
        .motor_ready(motor_ready), .mode(mode), .bsy_set(bsy_set),
        .bsy_clr(bsy_clr), .spin_start(spin_start), .spin_stop(spin_stop));

    function automatic logic [7:0] ev(input logic bs, bc, ss, sp, input logic [1:0] m);
        return {bs, bc, ss, sp, 2'b00, m};
    endfunction

    task automatic expect_ev(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Monitor: each output event (any pulse or a mode change) is compared with the queue head.
    always @(negedge clk) begin
        if (rst_n && (bsy_set || bsy_clr || spin_start || spin_stop || mode != prev_mode)) begin
            logic [7:0] got;
            got = {bsy_set, bsy_clr, spin_start, spin_stop, 2'b00, mode};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6/R10 quiet: got event %h expected none", got);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e != got) begin
                    n_bad++;
                    $display("FAIL %s: got event %h expected %h", t, got, e);
                end
            end
            prev_mode = mode;
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    // Spin-up from standby by a media access; BSY must wait for motor_ready (R8).
    task automatic wake;
        expect_ev(ev(1,0,0,0,2'd2), "R8 set");
        expect_ev(ev(0,0,1,0,2'd2), "R8 spin");
        expect_ev(ev(0,1,0,0,2'd0), "R8 clr");
        pulse(media_acc);
        repeat (3) @(negedge clk);
        check("R8 held in standby", mode, 2);
        pulse(motor_ready);
        check("R8 active after ready", mode, 0);
    endtask

    // Arm the timer through idle-with-timer and count the edges up to standby.
    task automatic tmr_case(input logic [7:0] code, input int lim, input string tag);
        int n;
        expect_ev(ev(1,0,0,0,2'd0), tag);
        expect_ev(ev(0,1,0,0,2'd1), tag);
        expect_ev(ev(0,0,0,1,2'd2), tag);
        tmr_code = code;
        tick = 1'b1;
        pulse(cmd_idle_tmr);
        n = 0;
        while (mode != 2'd2 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(tag, n, lim + 2);
        tick = 1'b0;
        wake();
    endtask

    initial begin
        int n;
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R11 reset mode", mode, 0);
        check("R11 reset pulses", {bsy_set, bsy_clr, spin_start, spin_stop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 mode after reset", mode, 0);

        // R9 standby now from active: set, then clear with stop
        expect_ev(ev(1,0,0,0,2'd0), "R9 set");
        expect_ev(ev(0,1,0,1,2'd2), "R9 stop");
        pulse(cmd_stby_now);
        @(negedge clk);
        check("R9 standby", mode, 2);

        // R9 idle now from standby needs a spin-up
        expect_ev(ev(1,0,0,0,2'd2), "R9 set");
        expect_ev(ev(0,0,1,0,2'd2), "R9 spin");
        expect_ev(ev(0,1,0,0,2'd1), "R9 clr idle");
        pulse(cmd_idle_now);
        repeat (6) @(negedge clk);
        check("R9 waits for ready", mode, 2);
        pulse(motor_ready);
        check("R9 idle after ready", mode, 1);

        // R7 media access in idle returns to active without busy
        expect_ev(ev(0,0,0,0,2'd0), "R7 direct");
        pulse(media_acc);
        check("R7 active", mode, 0);

        // R8 standby then wake by access
        expect_ev(ev(1,0,0,0,2'd0), "R9 set");
        expect_ev(ev(0,1,0,1,2'd2), "R9 stop");
        pulse(cmd_stby_now);
        wake();

        tmr_case(8'd0,   360*STEP, "R1 code 0");
        tmr_case(8'd1,   3*STEP,   "R2 code 1");
        tmr_case(8'd3,   3*STEP,   "R2 code 3");
        tmr_case(8'd4,   4*STEP,   "R3 code 4");
        tmr_case(8'd17,  17*STEP,  "R3 code 17");
        tmr_case(8'd240, 240*STEP, "R3 code 240");
        tmr_case(8'd241, 240*STEP, "R4 code 241");

        // R6 hold: ticks in standby cause nothing
        expect_ev(ev(1,0,0,0,2'd0), "R4 code 255");
        expect_ev(ev(0,1,0,0,2'd1), "R4 code 255");
        expect_ev(ev(0,0,0,1,2'd2), "R4 code 255");
        tmr_code = 8'd255;
        tick = 1'b1;
        pulse(cmd_idle_tmr);
        n = 0;
        while (mode != 2'd2 && n < 3000) begin @(negedge clk); n++; end
        check("R4 code 255", n, 240*STEP + 2);
        repeat (60) @(negedge clk);
        check("R6 held in standby", mode, 2);
        tick = 1'b0;
        wake();

        // R5/R7: access part way through restarts both countdowns
        expect_ev(ev(1,0,0,0,2'd0), "R7 arm");
        expect_ev(ev(0,1,0,0,2'd1), "R7 arm");
        tmr_code = 8'd5;
        tick = 1'b1;
        pulse(cmd_idle_tmr);
        repeat (4) @(negedge clk);
        expect_ev(ev(0,0,0,0,2'd0), "R7 direct");
        expect_ev(ev(0,0,0,0,2'd1), "R5 auto idle");
        expect_ev(ev(0,0,0,1,2'd2), "R6 expiry");
        pulse(media_acc);
        n = 0;
        while (mode != 2'd1 && n < 100) begin @(negedge clk); n++; end
        check("R5 idle after IDLE_TICKS", n, IDLT);
        while (mode != 2'd2 && n < 100) begin @(negedge clk); n++; end
        check("R7 standby after reload", n, 5*STEP);
        tick = 1'b0;
        wake();

        // R10 sleep ignores everything but hw_reset
        expect_ev(ev(1,0,0,0,2'd0), "R10 set");
        expect_ev(ev(0,1,0,1,2'd3), "R10 sleep");
        pulse(cmd_sleep);
        tick = 1'b1;
        pulse(cmd_idle_now);
        pulse(cmd_stby_tmr);
        pulse(media_acc);
        repeat (20) @(negedge clk);
        check("R10 still asleep", mode, 3);
        tick = 1'b0;
        expect_ev(ev(1,0,0,0,2'd3), "R10 reset set");
        expect_ev(ev(0,0,1,0,2'd3), "R10 reset spin");
        expect_ev(ev(0,1,0,0,2'd0), "R10 reset clr");
        pulse(hw_reset);
        repeat (4) @(negedge clk);
        check("R10 waits for ready", mode, 3);
        pulse(motor_ready);
        check("R10 active after reset", mode, 0);

        // R6 timer off after hw_reset: idle but never standby
        expect_ev(ev(0,0,0,0,2'd1), "R5 auto idle");
        tick = 1'b1;
        repeat (900) @(negedge clk);
        check("R6 timer off after reset", mode, 1);
        tick = 1'b0;

        check("R9 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule